// File: doc/BRIEF.md
# I2C Target Register Access Port

This block is an I2C target that lets an external bus master read and write a bank of byte-wide registers held elsewhere in the chip. SCL and SDA are brought into a fast system clock domain through a synchroniser, and bus edges are found on that clock. SDA is driven open-drain. The block only pulls the line low or releases it. Toward the inside of the chip the block offers a plain register port. It has a one-cycle write strobe with an address and a data byte, and a read address whose data must come back combinationally in the same cycle.

The master selects a register with a 16-bit subaddress sent as two bytes, high byte first. A write carries data bytes after the subaddress. A read sets the subaddress the same way, then uses a repeated start and the device address with the read direction. The subaddress advances by one after each data byte in both directions. The implemented window is a parameterised base address plus a register count. Subaddresses outside the window are refused. At the top of the window, reads keep returning the last register, and writes are refused.

Top module: `i2c_regport`

## Requirements
- R1: The 7-bit device address is the parameter `DEV_HI` (upper five bits) followed by `addr_sel[1:0]`. A first byte whose upper seven bits match is acknowledged by holding SDA low during the ninth SCL pulse. A non-matching first byte is left unacknowledged, and the block goes idle.
- R2: Bit 0 of the first byte selects the direction. A 0 means the master writes and subaddress bytes follow. A 1 means the master reads and data is sent from the current subaddress.
- R3: The two subaddress bytes arrive high byte first, and the high byte is always acknowledged. The low byte is acknowledged only when the full 16-bit value lies in [`SUB_BASE`, `SUB_BASE`+`NUM_REGS`-1]. Otherwise it is not acknowledged and the block goes idle.
- R4: Each write data byte aimed at a valid subaddress is acknowledged. It produces exactly one single-cycle `reg_we` pulse with `reg_waddr` equal to the subaddress and `reg_wdata` equal to the byte. The subaddress then advances by one.
- R5: A write data byte aimed past the top register produces no `reg_we` pulse and is not acknowledged, and the block goes idle.
- R6: Read bytes are sent MSB first from `reg_rdata` at `reg_raddr`. A master acknowledge advances the subaddress by one, but never past the top register, which is then repeated. `reg_raddr` always stays inside the window.
- R7: A master non-acknowledge (SDA high on the ninth pulse of a read byte) ends the read. SDA is released, and the block ignores the bus until the next start.
- R8: A stop (SDA rising while SCL is high) at any bit position sends the block to idle with SDA released. A start (SDA falling while SCL is high) at any bit position restarts reception of a device-address byte.
- R9: A stop followed by a start within one SCL high period begins a new, fully working transfer.
- R10: The block begins pulling SDA low only while SCL is low.
- R11: During and just after reset, SDA is released and `reg_we` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 2 | Low two bits of the device address |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_waddr | output | 16 | Register write subaddress |
| reg_wdata | output | 8 | Register write data |
| reg_raddr | output | 16 | Register read subaddress |
| reg_rdata | input | 8 | Register read data, valid in the same cycle as `reg_raddr` |

## Verification
Two events can land in the same SCL high period: a stop that must idle the block, and a start that must re-arm it. The bench creates this by raising and then lowering SDA within a single SCL high phase. It then requires that the next device address, subaddress and data byte are all acknowledged and that the write strobe appears with the right address and data. The same pairing of a bus condition with byte handling is covered by a stop and by a repeated start placed in the middle of a byte. The bench requires the aborted byte to leave no write behind and the following transfer to work normally.

// File: rtl/i2c_rp_pkg.sv
// Package: shared types for the I2C target register port.
// Assumes: nothing beyond IEEE 1800-2017.
package i2c_rp_pkg;

    // Protocol engine states
    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for a start condition
        ST_RX,      // shifting in a byte from the master
        ST_ACKW,    // byte accepted, waiting for SCL low to pull SDA
        ST_ACK,     // holding SDA low through the ninth pulse
        ST_TX,      // shifting a byte out to the master
        ST_MACK,    // SDA released, sampling the master acknowledge
        ST_MHOLD    // master acknowledged, waiting for SCL low to reload
    } eng_state_t;

    // Meaning of the byte currently being received
    typedef enum logic [1:0] {
        BK_DEV,     // device address plus direction
        BK_SUBH,    // subaddress high byte
        BK_SUBL,    // subaddress low byte
        BK_DATA     // write data
    } byte_kind_t;

endpackage

// File: rtl/i2c_rp_sync.sv
// Module: i2c_rp_sync
// Brings SCL and SDA into the system clock domain and flags bus events:
// SCL rising and falling edges, start (SDA falls while SCL high) and
// stop (SDA rises while SCL high).
// Assumes: the system clock is several times faster than SCL and the
// lines idle high, so the registers reset to 1 to avoid spurious events.
module i2c_rp_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] scl_pipe;
    logic [MSB:0] sda_pipe;
    logic         scl_q;
    logic         sda_q;

    // Shift both lines through the synchroniser chain and keep one older copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[MSB-1:0], scl_i};
            sda_pipe <= {sda_pipe[MSB-1:0], sda_i};
            scl_q    <= scl_pipe[MSB];
            sda_q    <= sda_pipe[MSB];
        end
    end

    // Decode edges and bus conditions from current and previous samples
    always_comb begin
        scl_s     = scl_pipe[MSB];
        sda_s     = sda_pipe[MSB];
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_evt = scl_s & scl_q & sda_q & ~sda_s;
        stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/i2c_rp_engine.sv
// Module: i2c_rp_engine
// Byte-level protocol engine: device address match, two-byte subaddress
// capture with window check, write strobes, read shifting with top-register
// hold, acknowledge generation, and start/stop override at any bit.
// Assumes: events come from i2c_rp_sync. SDA is only pulled after SCL is
// seen low. reg_rdata answers reg_raddr in the same cycle.
module i2c_rp_engine
    import i2c_rp_pkg::*;
#(
    parameter logic [4:0]  DEV_HI   = 5'b01110,
    parameter logic [15:0] SUB_BASE = 16'h4000,
    parameter int          NUM_REGS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_s,
    input  logic        sda_s,
    input  logic        scl_rise,
    input  logic        scl_fall,
    input  logic        start_evt,
    input  logic        stop_evt,
    input  logic [1:0]  addr_sel,
    output logic        sda_oe,
    output logic        reg_we,
    output logic [15:0] reg_waddr,
    output logic [7:0]  reg_wdata,
    output logic [15:0] reg_raddr,
    input  logic [7:0]  reg_rdata
);
    localparam logic [15:0] SUB_TOP = 16'(SUB_BASE + NUM_REGS - 1);

    eng_state_t state;
    byte_kind_t kind;
    logic [2:0]  bitcnt;
    logic [6:0]  shreg;
    logic [6:0]  txreg;
    logic [7:0]  sub_hi;
    logic [15:0] ptr;
    logic        go_tx;

    logic [7:0]  byte_in;
    logic [15:0] sub_full;
    logic        dev_hit;
    logic        sub_ok;
    logic        wr_ok;

    // Decode the byte completing on this SCL rise and the window checks
    always_comb begin
        byte_in   = {shreg, sda_s};
        sub_full  = {sub_hi, byte_in};
        dev_hit   = (byte_in[7:1] == {DEV_HI, addr_sel});
        sub_ok    = (sub_full >= SUB_BASE) && (sub_full <= SUB_TOP);
        wr_ok     = (ptr <= SUB_TOP);
        reg_raddr = (ptr > SUB_TOP) ? SUB_TOP : ptr;
    end

    // Protocol sequencing; stop and start override every state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            kind      <= BK_DEV;
            bitcnt    <= '0;
            shreg     <= '0;
            txreg     <= '0;
            sub_hi    <= '0;
            ptr       <= SUB_BASE;
            go_tx     <= 1'b0;
            sda_oe    <= 1'b0;
            reg_we    <= 1'b0;
            reg_waddr <= '0;
            reg_wdata <= '0;
        end else begin
            reg_we <= 1'b0;
            if (stop_evt) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (start_evt) begin
                state  <= ST_RX;
                kind   <= BK_DEV;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_RX: if (scl_rise) begin
                        shreg  <= byte_in[6:0];
                        bitcnt <= bitcnt + 3'd1;
                        if (bitcnt == 3'd7) begin
                            state <= ST_ACKW;
                            go_tx <= 1'b0;
                            case (kind)
                                BK_DEV: begin
                                    if (!dev_hit) state <= ST_IDLE;
                                    go_tx <= byte_in[0];
                                    kind  <= BK_SUBH;
                                end
                                BK_SUBH: begin
                                    sub_hi <= byte_in;
                                    kind   <= BK_SUBL;
                                end
                                BK_SUBL: begin
                                    if (sub_ok) ptr <= sub_full;
                                    else        state <= ST_IDLE;
                                    kind <= BK_DATA;
                                end
                                default: begin
                                    if (wr_ok) begin
                                        reg_we    <= 1'b1;
                                        reg_waddr <= ptr;
                                        reg_wdata <= byte_in;
                                        ptr       <= ptr + 16'd1;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                            endcase
                        end
                    end
                    ST_ACKW: if (scl_fall) begin
                        sda_oe <= 1'b1;
                        state  <= ST_ACK;
                    end
                    ST_ACK, ST_MHOLD: if (scl_fall) begin
                        bitcnt <= '0;
                        if (go_tx || state == ST_MHOLD) begin
                            txreg  <= reg_rdata[6:0];
                            sda_oe <= ~reg_rdata[7];
                            state  <= ST_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_RX;
                        end
                    end
                    ST_TX: if (scl_fall) begin
                        if (bitcnt == 3'd7) begin
                            sda_oe <= 1'b0;
                            state  <= ST_MACK;
                        end else begin
                            sda_oe <= ~txreg[6];
                            txreg  <= {txreg[5:0], 1'b0};
                            bitcnt <= bitcnt + 3'd1;
                        end
                    end
                    ST_MACK: if (scl_rise) begin
                        if (!sda_s) begin
                            if (ptr < SUB_TOP) ptr <= ptr + 16'd1;
                            state <= ST_MHOLD;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Pulling SDA low starts only in the SCL low phase
    assert_pull_in_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // A stop leaves SDA released on the next cycle
    assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe);

    // Write strobes only hit the implemented window
    assert_write_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (reg_waddr >= SUB_BASE && reg_waddr <= SUB_TOP));

    // Write strobe lasts a single cycle
    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // Read address never leaves the window
    assert_read_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_raddr >= SUB_BASE && reg_raddr <= SUB_TOP);

endmodule

// File: rtl/i2c_regport.sv
// Module: i2c_regport
// Top of the I2C target register port: synchroniser/event decoder plus
// protocol engine. SDA output is open-drain (sda_oe=1 pulls low).
// Assumes: the clock is much faster than SCL, and the external register
// bank answers reg_raddr combinationally on reg_rdata.
module i2c_regport #(
    parameter logic [4:0]  DEV_HI      = 5'b01110,
    parameter logic [15:0] SUB_BASE    = 16'h4000,
    parameter int          NUM_REGS    = 8,
    parameter int          SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    input  logic [1:0]  addr_sel,
    output logic        sda_oe,
    output logic        reg_we,
    output logic [15:0] reg_waddr,
    output logic [7:0]  reg_wdata,
    output logic [15:0] reg_raddr,
    input  logic [7:0]  reg_rdata
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

    // Line synchronisation and bus event decode
    i2c_rp_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    // Byte protocol and register port
    i2c_rp_engine #(
        .DEV_HI   (DEV_HI),
        .SUB_BASE (SUB_BASE),
        .NUM_REGS (NUM_REGS)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .addr_sel  (addr_sel),
        .sda_oe    (sda_oe),
        .reg_we    (reg_we),
        .reg_waddr (reg_waddr),
        .reg_wdata (reg_wdata),
        .reg_raddr (reg_raddr),
        .reg_rdata (reg_rdata)
    );

endmodule

// File: tb/i2c_regport_tb.sv
// Bench: drives the bus as a master and keeps a behavioural model.
// The model holds expected register contents and a queue of expected write
// strobes, and is compared with the port on every clock.
module i2c_regport_tb;
    localparam int          Q      = 20;        // quarter SCL period, clocks
    localparam logic [15:0] BASE   = 16'h4000;
    localparam int          NREG   = 8;
    localparam logic [7:0]  DEV_W  = 8'h72;     // address 0x39, write
    localparam logic [7:0]  DEV_R  = 8'h73;     // address 0x39, read
    localparam logic [7:0]  DEV_X  = 8'h74;     // address 0x3A, not ours

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  addr_sel = 2'b01;
    logic        sda_oe, reg_we;
    logic [15:0] reg_waddr, reg_raddr;
    logic [7:0]  reg_wdata, reg_rdata;
    logic        sda_bus;

    logic [7:0]  mem     [NREG];
    logic [7:0]  exp_mem [NREG];
    logic [23:0] wq[$];
    int          nchk = 0;
    int          nerr = 0;
    logic        oe_prev = 1'b0;
    logic        done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    assign sda_bus   = sda_m & ~sda_oe;
    assign reg_rdata = mem[3'(reg_raddr - BASE)];

    i2c_regport u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_bus),
        .addr_sel  (addr_sel),
        .sda_oe    (sda_oe),
        .reg_we    (reg_we),
        .reg_waddr (reg_waddr),
        .reg_wdata (reg_wdata),
        .reg_raddr (reg_raddr),
        .reg_rdata (reg_rdata)
    );

    // Register bank the block writes into
    always @(posedge clk) if (reg_we) mem[3'(reg_waddr - BASE)] <= reg_wdata;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison: write strobes against the queue, SDA pull timing
    always @(negedge clk) if (rst_n && !done) begin
        if (reg_we) begin
            if (wq.size() == 0) chk("R5 unexpected write strobe", {8'h0, reg_waddr, reg_wdata}, 32'hFFFFFFFF);
            else chk("R4 write strobe addr/data", {8'h0, reg_waddr, reg_wdata}, {8'h0, wq.pop_front()});
        end
        if (sda_oe && !oe_prev) chk("R10 SDA pulled while SCL low", {31'h0, scl_m}, 32'h0);
        oe_prev <= sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    // Stop then start inside one SCL high period
    task automatic bus_stop_start();
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        sda_m = b; tick(Q); scl_m = 1'b1; tick(Q);
        s = sda_bus; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        chk(tag, {31'h0, s}, {31'h0, ~exp_ack});
    endtask

    task automatic recv_byte(input logic [7:0] exp, input logic mack, input string tag);
        logic s;
        logic [7:0] got;
        for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); got[i] = s; end
        chk(tag, {24'h0, got}, {24'h0, exp});
        clk_bit(~mack, s);
    endtask

    task automatic push_wr(input logic [15:0] a, input logic [7:0] d);
        wq.push_back({a, d});
        exp_mem[3'(a - BASE)] = d;
    endtask

    task automatic set_sub(input logic [15:0] a);
        send_byte(DEV_W, 1'b1, "R1 device address ack");
        send_byte(a[15:8], 1'b1, "R3 subaddress high ack");
        send_byte(a[7:0], 1'b1, "R3 subaddress low ack");
    endtask

    task automatic end_summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual=running expected=finished");
        end_summary();
    end

    initial begin
        logic s;
        for (int i = 0; i < NREG; i++) begin
            mem[i] = 8'hA0 + 8'(i);
            exp_mem[i] = 8'hA0 + 8'(i);
        end
        tick(5);
        chk("R11 SDA released in reset", {31'h0, sda_oe}, 32'h0);
        chk("R11 no strobe in reset", {31'h0, reg_we}, 32'h0);
        rst_n = 1'b1;
        tick(10);
        chk("R11 SDA released after reset", {31'h0, sda_oe}, 32'h0);

        // Plain write of two bytes with auto-increment
        bus_start();
        set_sub(16'h4002);
        push_wr(16'h4002, 8'h11); send_byte(8'h11, 1'b1, "R4 data ack");
        push_wr(16'h4003, 8'h22); send_byte(8'h22, 1'b1, "R4 data ack");
        bus_stop();
        chk("R4 all strobes seen", wq.size(), 0);

        // Read back with repeated start
        bus_start();
        set_sub(16'h4002);
        bus_start();
        send_byte(DEV_R, 1'b1, "R2 read address ack");
        recv_byte(exp_mem[2], 1'b1, "R6 read byte 0");
        recv_byte(exp_mem[3], 1'b0, "R6 read byte 1");
        tick(Q);
        chk("R7 SDA released after master NACK", {31'h0, sda_oe}, 32'h0);
        send_byte(8'h00, 1'b0, "R7 bus ignored after NACK");
        bus_stop();

        // Wrong device address
        bus_start();
        send_byte(DEV_X, 1'b0, "R1 foreign address not acked");
        bus_stop();

        // Subaddress outside the window
        bus_start();
        send_byte(DEV_W, 1'b1, "R1 device address ack");
        send_byte(8'h40, 1'b1, "R3 high byte acked");
        send_byte(8'h10, 1'b0, "R3 invalid low byte not acked");
        send_byte(8'h55, 1'b0, "R3 idle after invalid subaddress");
        bus_stop();

        // Write running past the top register
        bus_start();
        set_sub(16'h4006);
        push_wr(16'h4006, 8'h66); send_byte(8'h66, 1'b1, "R4 data ack");
        push_wr(16'h4007, 8'h77); send_byte(8'h77, 1'b1, "R4 top data ack");
        send_byte(8'h88, 1'b0, "R5 overflow byte not acked");
        bus_stop();
        chk("R5 no extra strobe", wq.size(), 0);

        // Read running past the top register holds the top value
        bus_start();
        set_sub(16'h4006);
        bus_start();
        send_byte(DEV_R, 1'b1, "R2 read address ack");
        recv_byte(8'h66, 1'b1, "R6 read 0x4006");
        recv_byte(8'h77, 1'b1, "R6 read top");
        recv_byte(8'h77, 1'b1, "R6 top held");
        recv_byte(8'h77, 1'b0, "R6 top held again");
        bus_stop();

        // Stop in the middle of a byte
        bus_start();
        send_byte(DEV_W, 1'b1, "R1 device address ack");
        clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b0, s);
        bus_stop();
        tick(Q);
        chk("R8 SDA released after mid-byte stop", {31'h0, sda_oe}, 32'h0);
        bus_start();
        set_sub(16'h4000);
        push_wr(16'h4000, 8'h5A); send_byte(8'h5A, 1'b1, "R8 write after stop");
        bus_stop();

        // Start in the middle of a byte
        bus_start();
        send_byte(DEV_W, 1'b1, "R1 device address ack");
        clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b0, s);
        bus_start();
        set_sub(16'h4001);
        push_wr(16'h4001, 8'hC3); send_byte(8'hC3, 1'b1, "R8 write after mid-byte start");
        bus_stop();

        // Stop and start inside one SCL high period
        bus_start();
        set_sub(16'h4003);
        push_wr(16'h4003, 8'h3C); send_byte(8'h3C, 1'b1, "R4 data ack");
        bus_stop_start();
        send_byte(DEV_W, 1'b1, "R9 address after stop+start");
        send_byte(8'h40, 1'b1, "R9 subaddress high");
        send_byte(8'h05, 1'b1, "R9 subaddress low");
        push_wr(16'h4005, 8'h5C); send_byte(8'h5C, 1'b1, "R9 data ack");
        bus_stop();
        chk("R9 strobes after stop+start", wq.size(), 0);

        // Final read of the low registers
        bus_start();
        set_sub(16'h4000);
        bus_start();
        send_byte(DEV_R, 1'b1, "R2 read address ack");
        for (int i = 0; i < 6; i++) recv_byte(exp_mem[i], i < 5, "R6 sequential read");
        bus_stop();
        tick(Q);
        end_summary();
    end

endmodule